// File: doc/BRIEF.md
# Sample capture and replay buffer

This block records a slow stream of 16-bit converter samples into on-chip memory and then plays them back. A start pulse latches a sample count and opens a capture phase. Every clock edge that sees the input strobe high stores the input word at the next flat address, beginning at zero. Once the latched count of words has been stored, the block moves straight into replay. Replay reads the same addresses back in order from zero and hands each word out over a valid/ready handshake. When every word has been accepted, the block rests in a finished state. From there a replay pulse plays the stored record again, or a start pulse begins a fresh capture.

The storage is a synchronous dual-port array. The writer and the reader each have their own address. The flat address space is split into equal banks: the upper address bits pick a bank and the lower bits index within it. With the default parameters there are three banks of 1024 words. Setting `BANK_AW` to 12 gives three 4096-word banks, 12288 words in all. Reads are registered, so the read address is presented one clock before its data. The bank chosen for a read is registered together with the read, so the output multiplexer picks the matching bank one cycle later. One system clock drives the control logic and the memory. The reset is synchronous and active high.

Top module: `sample_replay_buf`

## Requirements
- R1: During and right after a synchronous reset, `capturing`, `replaying`, `done` and `out_valid` are all low.
- R2: A `start` pulse while idle or finished latches `cfg_count`, and `capturing` is high in the following cycle.
- R3: Words written during capture are replayed in arrival order from address 0 with identical values, across every bank boundary of the flat address space.
- R4: `in_valid` has no effect outside the capture phase: when the block is idle, replaying or finished, nothing is stored.
- R5: The edge that stores the count-th sample ends capture: in the next cycle `capturing` is low and `replaying` is high, and later strobes are not stored.
- R6: A word is transferred on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R7: `out_valid` is high only while `replaying` is high. Exactly the latched count of words is delivered, after which `done` goes high with `out_valid` low.
- R8: `out_valid` first rises one cycle after `replaying` rises. With `out_ready` held high, one word is delivered per cycle, and `done` rises count cycles after the first `out_valid`.
- R9: A `replay` pulse while finished starts another replay of the same stored words from address 0.
- R10: `start` and `replay` are ignored while capturing or replaying. When both pulse together while finished, `start` wins.
- R11: A count larger than the total depth is clamped to the depth. A count of zero passes through replay to `done` without delivering any word.
- R12: At most one of `capturing`, `replaying` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for control and memory |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse: latch count and begin capture |
| replay | input | 1 | Pulse: replay stored words again when finished |
| cfg_count | input | PTR_W (12) | Number of samples to capture and replay |
| in_valid | input | 1 | Sample strobe, one word stored per high edge |
| in_data | input | DATA_W (16) | Sample word |
| out_ready | input | 1 | Downstream accepts the current word |
| out_valid | output | 1 | `out_data` carries a replayed word |
| out_data | output | DATA_W (16) | Replayed word |
| capturing | output | 1 | Capture phase active |
| replaying | output | 1 | Replay phase active |
| done | output | 1 | Replay finished |

## Verification
Each result has a fixed latency. `capturing` follows the accepted `start` edge by one cycle. `replaying` follows the edge that stores the last sample by one cycle. The first `out_valid` comes one cycle later still, and with `out_ready` held high, `done` rises exactly count cycles after that first `out_valid`. The bench drives inputs just after a rising edge and samples every output at the falling edge, so each of these timing checks reads the cycle in which the registered output must already have changed. A scoreboard queue holds the expected words in order. A monitor pops one entry on every falling edge where `out_valid` and `out_ready` are both high, and also checks that a word which stalled on the previous cycle is still present and unchanged.

// File: rtl/srb_pkg.sv
package srb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_CAPTURE = 2'd1,
      ST_REPLAY  = 2'd2,
      ST_DONE    = 2'd3
   } srb_state_e;

   function automatic int srb_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/srb_bank.sv
module srb_bank #(
   parameter int DATA_W = 16,
   parameter int AW     = 10
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int WORDS = 1 << AW;

   logic [DATA_W-1:0] store [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
      if (rd_en) rd_data <= store[rd_addr];
   end
endmodule

// File: rtl/srb_banked_mem.sv
module srb_banked_mem #(
   parameter int DATA_W    = 16,
   parameter int BANK_AW   = 10,
   parameter int NUM_BANKS = 3,
   parameter int ADDR_W    = 12
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (NUM_BANKS == 1) begin : g_single
         srb_bank #(.DATA_W(DATA_W), .AW(BANK_AW)) u_bank (
            .clk     (clk),
            .wr_en   (wr_en),
            .wr_addr (wr_addr[BANK_AW-1:0]),
            .wr_data (wr_data),
            .rd_en   (rd_en),
            .rd_addr (rd_addr[BANK_AW-1:0]),
            .rd_data (rd_data)
         );
      end else begin : g_multi
         localparam int SEL_W = ADDR_W - BANK_AW;

         logic [SEL_W-1:0]  wr_sel;
         logic [SEL_W-1:0]  rd_sel;
         logic [SEL_W-1:0]  rd_sel_q;
         logic [DATA_W-1:0] bank_q [NUM_BANKS];

         assign wr_sel = wr_addr[ADDR_W-1:BANK_AW];
         assign rd_sel = rd_addr[ADDR_W-1:BANK_AW];

         // bank choice travels with the read so the mux matches the data cycle
         always_ff @(posedge clk) begin
            if (rd_en) rd_sel_q <= rd_sel;
         end

         for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic bank_we;
            assign bank_we = wr_en && (wr_sel == SEL_W'(b));
            srb_bank #(.DATA_W(DATA_W), .AW(BANK_AW)) u_bank (
               .clk     (clk),
               .wr_en   (bank_we),
               .wr_addr (wr_addr[BANK_AW-1:0]),
               .wr_data (wr_data),
               .rd_en   (rd_en),
               .rd_addr (rd_addr[BANK_AW-1:0]),
               .rd_data (bank_q[b])
            );
         end

         always_comb begin
            rd_data = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
               if (rd_sel_q == SEL_W'(b)) rd_data = bank_q[b];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/srb_ctrl.sv
module srb_ctrl
   import srb_pkg::*;
#(
   parameter int DEPTH  = 3072,
   parameter int PTR_W  = 12,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              replay,
   input  logic [PTR_W-1:0]  cfg_count,
   input  logic              in_valid,
   input  logic              out_ready,
   output srb_state_e        state,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              out_valid
);
   localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
   localparam logic [PTR_W-1:0] ONE_P   = PTR_W'(1);

   srb_state_e       state_q, state_d;
   logic [PTR_W-1:0] wr_ptr, rd_ptr, lim_q;
   logic             ov_q;
   logic             start_ok, replay_ok, wr_left, wr_fire, slot_free, rd_fire;

   always_comb begin
      start_ok  = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
      replay_ok = replay && !start && (state_q == ST_DONE);
      wr_left   = (wr_ptr != lim_q);
      wr_fire   = (state_q == ST_CAPTURE) && in_valid && wr_left;
      slot_free = !ov_q || out_ready;
      rd_fire   = (state_q == ST_REPLAY) && (rd_ptr != lim_q) && slot_free;

      state_d = state_q;
      case (state_q)
         ST_IDLE, ST_DONE: begin
            if (start_ok)       state_d = ST_CAPTURE;
            else if (replay_ok) state_d = ST_REPLAY;
         end
         ST_CAPTURE: begin
            if (!wr_left || (wr_fire && ((wr_ptr + ONE_P) == lim_q)))
               state_d = ST_REPLAY;
         end
         ST_REPLAY: begin
            if ((rd_ptr == lim_q) && slot_free) state_d = ST_DONE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         lim_q   <= '0;
         ov_q    <= 1'b0;
      end else begin
         state_q <= state_d;

         if (start_ok) begin
            lim_q  <= (cfg_count > DEPTH_P) ? DEPTH_P : cfg_count;
            wr_ptr <= '0;
         end else if (wr_fire) begin
            wr_ptr <= wr_ptr + ONE_P;
         end

         if ((state_d == ST_REPLAY) && (state_q != ST_REPLAY)) rd_ptr <= '0;
         else if (rd_fire)                                        rd_ptr <= rd_ptr + ONE_P;

         if (state_q != ST_REPLAY) ov_q <= 1'b0;
         else if (rd_fire)         ov_q <= 1'b1;
         else if (out_ready)       ov_q <= 1'b0;
      end
   end

   assign state     = state_q;
   assign wr_en     = wr_fire;
   assign wr_addr   = wr_ptr[ADDR_W-1:0];
   assign rd_en     = rd_fire;
   assign rd_addr   = rd_ptr[ADDR_W-1:0];
   assign out_valid = ov_q;
endmodule

// File: rtl/sample_replay_buf.sv
module sample_replay_buf
   import srb_pkg::*;
#(
   parameter int  DATA_W    = 16,
   parameter int  BANK_AW   = 10,
   parameter int  NUM_BANKS = 3,
   localparam int DEPTH     = NUM_BANKS << BANK_AW,
   localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 0,
   localparam int ADDR_W    = BANK_AW + SEL_W,
   localparam int PTR_W     = srb_max($clog2(DEPTH + 1), ADDR_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              replay,
   input  logic [PTR_W-1:0]  cfg_count,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              capturing,
   output logic              replaying,
   output logic              done
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("sample_replay_buf: DATA_W must be at least 1");
      end
      if (BANK_AW < 1) begin : g_bad_bank
         $error("sample_replay_buf: BANK_AW must be at least 1");
      end
      if (NUM_BANKS < 1) begin : g_bad_count
         $error("sample_replay_buf: NUM_BANKS must be at least 1");
      end
   endgenerate

   srb_state_e        state;
   logic              wr_en, rd_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;

   srb_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .replay    (replay),
      .cfg_count (cfg_count),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .state     (state),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .out_valid (out_valid)
   );

   srb_banked_mem #(
      .DATA_W    (DATA_W),
      .BANK_AW   (BANK_AW),
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W)
   ) u_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (in_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (out_data)
   );

   assign capturing = (state == ST_CAPTURE);
   assign replaying = (state == ST_REPLAY);
   assign done      = (state == ST_DONE);
endmodule

// File: rtl/srb_checker.sv
module srb_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              replay,
   input logic              out_ready,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              capturing,
   input logic              replaying,
   input logic              done
);
   p_flags_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
      $onehot0({capturing, replaying, done}));

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   p_valid_in_replay_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> replaying);

   p_capture_exit_r5: assert property (@(posedge clk) disable iff (rst)
      capturing |=> (capturing || replaying));

   p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (done && !start && !replay) |=> done);

   p_replay_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
      replaying |=> (replaying || done));
endmodule

bind sample_replay_buf srb_checker #(.DATA_W(DATA_W)) u_srb_checker (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .replay    (replay),
   .out_ready (out_ready),
   .out_valid (out_valid),
   .out_data  (out_data),
   .capturing (capturing),
   .replaying (replaying),
   .done      (done)
);

// File: tb/test_sample_replay_buf.sv
`timescale 1ns/1ps
module test_sample_replay_buf;
   localparam int DW    = 16;
   localparam int DEPTH = 3072;
   localparam int PW    = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0, replay = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
   logic [PW-1:0] cfg_count = '0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid, capturing, replaying, done;
   logic [DW-1:0] out_data;

   sample_replay_buf i_sample_replay_buf (
      .clk(clk), .rst(rst), .start(start), .replay(replay), .cfg_count(cfg_count),
      .in_valid(in_valid), .in_data(in_data), .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data),
      .capturing(capturing), .replaying(replaying), .done(done)
   );

   always #2.5 clk = ~clk;

   int            n_cmp = 0, n_bad = 0;
   logic [DW-1:0] exp_q [$];
   logic [DW-1:0] model [$];
   bit            rdy_random = 1'b0;
   logic [15:0]   lfsr = 16'hace1;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic logic [DW-1:0] smp(input int tag, input int i);
      return DW'((i * 40503) ^ (tag * 4099) ^ 23100);
   endfunction

   // ready driver
   initial begin
      forever begin
         @(posedge clk); #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = rdy_random ? lfsr[0] : 1'b1;
      end
   end

   // monitor: scoreboard compare and stall hold
   bit            stall_prev = 1'b0;
   logic [DW-1:0] stall_data = '0;
   initial begin
      forever begin
         @(negedge clk);
         if (rst) begin
            stall_prev = 1'b0;
         end else begin
            if (stall_prev)
               chk(out_valid && (out_data == stall_data), "R6 stalled word held",
                   int'(out_data), int'(stall_data));
            if (out_valid && out_ready) begin
               if (exp_q.size() == 0) chk(1'b0, "R7 word beyond count", int'(out_data), -1);
               else begin
                  logic [DW-1:0] e;
                  e = exp_q.pop_front();
                  chk(out_data == e, "R3 replayed data", int'(out_data), int'(e));
               end
            end
            stall_prev = out_valid && !out_ready;
            stall_data = out_data;
         end
      end
   end

   task automatic junk_strobes(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; in_valid = 1'b1; in_data = 16'hbad0 + DW'(i);
         @(posedge clk); #1; in_valid = 1'b0;
      end
   endtask

   task automatic do_start(input int cnt);
      @(posedge clk); #1; cfg_count = PW'(cnt); start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
      @(negedge clk);
      chk(capturing === 1'b1, "R2 capturing after start", int'(capturing), 1);
   endtask

   // captures n samples; gap idle cycles between them; optional mid-run start/replay pulse
   task automatic capture(input int tag, input int n, input int gap, input bit inject);
      model.delete();
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         in_valid = 1'b1; in_data = smp(tag, i);
         start  = inject && (i == n / 2);
         replay = inject && (i == n / 2);
         model.push_back(smp(tag, i));
         exp_q.push_back(smp(tag, i));
         if (gap > 0) begin
            @(posedge clk); #1; in_valid = 1'b0; start = 1'b0; replay = 1'b0;
            repeat (gap - 1) @(posedge clk);
         end
      end
      @(posedge clk); #1; in_valid = 1'b0; start = 1'b0; replay = 1'b0;
   endtask

   task automatic wait_done(input int cnt, input string tagmsg);
      while (!done) @(negedge clk);
      chk(exp_q.size() == 0, {"R7 all words delivered ", tagmsg}, exp_q.size(), 0);
      chk(out_valid == 1'b0, "R7 no valid when done", int'(out_valid), 0);
      chk(!capturing && !replaying, "R12 only done flag", int'({capturing, replaying}), 0);
      if (cnt < 0) $display("unused");
   endtask

   initial begin
      // watchdog
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({capturing, replaying, done, out_valid} == 4'b0, "R1 reset state",
          int'({capturing, replaying, done, out_valid}), 0);
      @(posedge clk); #1; rst = 1'b0;
      @(negedge clk);
      chk({capturing, replaying, done, out_valid} == 4'b0, "R1 idle after reset",
          int'({capturing, replaying, done, out_valid}), 0);

      // R4: strobes while idle are dropped
      junk_strobes(3);

      // short capture, back to back, exact timing with ready high
      do_start(5);
      capture(1, 5, 0, 1'b0);
      @(negedge clk);
      chk(replaying && !capturing, "R5 replay right after last write",
          int'({capturing, replaying}), 1);
      chk(out_valid == 1'b0, "R8 no valid in first replay cycle", int'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == 1'b1, "R8 valid one cycle after replay", int'(out_valid), 1);
      begin
         int c = 0;
         while (!done) begin @(negedge clk); c++; end
         chk(c == 5, "R8 one word per cycle", c, 5);
      end
      wait_done(5, "short");

      // R4 strobes while finished, then R9 replay of the same record
      junk_strobes(2);
      rdy_random = 1'b1;
      foreach (model[i]) exp_q.push_back(model[i]);
      @(posedge clk); #1; replay = 1'b1;
      @(posedge clk); #1; replay = 1'b0;
      @(negedge clk);
      chk(replaying === 1'b1, "R9 replay pulse starts replay", int'(replaying), 1);
      wait_done(5, "R9 replay");

      // R10: start wins over replay in the finished state
      @(posedge clk); #1; cfg_count = PW'(3); start = 1'b1; replay = 1'b1;
      @(posedge clk); #1; start = 1'b0; replay = 1'b0;
      @(negedge clk);
      chk(capturing && !replaying, "R10 start wins over replay", int'({capturing, replaying}), 2);
      capture(2, 3, 2, 1'b0);
      wait_done(3, "R10");

      // R11 clamp + R3 every bank + R10 pulses mid-capture + R4 strobes during replay
      do_start(4000);
      capture(3, DEPTH, 0, 1'b1);
      @(negedge clk);
      chk(replaying === 1'b1, "R11 count clamped to depth", int'(replaying), 1);
      junk_strobes(4);
      @(posedge clk); #1; cfg_count = PW'(2); start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
      wait_done(DEPTH, "full depth");

      // R11 zero count
      do_start(0);
      @(negedge clk);
      @(negedge clk);
      chk(done === 1'b1, "R11 zero count finishes", int'(done), 1);
      chk(exp_q.size() == 0, "R11 zero count no words", exp_q.size(), 0);

      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule